// File: doc/BRIEF.md
# Memory-Mapped Asynchronous Serial Port

This block is a full-duplex asynchronous serial port that sits on a simple single-cycle register bus. Software writes a byte to the data location to send it and reads the same location to collect the most recently received byte. Two status words report whether the transmitter can take another byte and whether a received byte is waiting, along with overrun and parity-error indications.

Both directions run on a shared tick at sixteen times the bit rate, derived from the system clock by a fixed divider. The transmitter serialises a frame: a low start bit, eight data bits least significant first, an optional parity bit, then a high stop period of one, one and a half or two bit times. The receiver resynchronises the incoming line through two flops and waits for a falling edge. It confirms the start bit half a bit later, then samples every following bit near the centre of its cell.

Top module: `sio_port`

## Requirements
- R1: After reset the serial output is high, the transmitter status word (offset 0x18) reads 1, and the receiver status word (offset 0x14), the data word (offset 0x10) and any unmapped offset read 0.
- R2: A bus write to offset 0x10 while the transmitter is idle drives the line low on the next cycle for a start bit, then sends bits 7:0 of the write data least significant first. Each bit lasts 16 ticks, and one tick is TICK_DIV clock cycles of a free-running divider.
- R3: When parity is enabled (cfgParityEn=1), a parity bit of 16 ticks follows data bit 7. With cfgParityOdd=0 the total number of ones in data plus parity is even, and with cfgParityOdd=1 it is odd.
- R4: The stop period is high for 16, 24 or 32 ticks for cfgStopSel 0, 1 and 2 (3 behaves as 2). Parity and stop settings are captured when a byte is accepted, and transmitter status bit 0 returns to 1 when the stop period ends.
- R5: From the cycle after a byte is accepted until the end of its stop period, transmitter status bit 0 reads 0, and a write to offset 0x10 during that time has no effect on the serial output.
- R6: A received frame makes bit 0 of the receiver status word read 1 and makes offset 0x10 return the byte in bits 7:0 with bits 31:8 zero.
- R7: A read of offset 0x10 clears receiver status bits 0 (ready) and 1 (overrun).
- R8: A low pulse on the serial input shorter than half a bit is discarded as a false start: no byte is delivered, and a following valid frame is received correctly.
- R9: With parity enabled, receiver status bit 2 is set when the received parity bit does not match the configured sense. It keeps that value until the next frame is delivered, which sets or clears it again.
- R10: A frame delivered while receiver status bit 0 is still 1 replaces the stored byte and sets receiver status bit 1.
- R11: Transmission and reception proceed at the same time without disturbing each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access in this cycle |
| busWr | input | 1 | 1 for write, 0 for read |
| busAddr | input | ADDR_W | Byte offset of the access |
| busWdata | input | BUS_W | Write data; only bits 7:0 are used |
| busRdata | output | BUS_W | Read data, valid in the cycle of the access |
| cfgParityEn | input | 1 | Parity bit present in frames |
| cfgParityOdd | input | 1 | 1 for odd parity, 0 for even |
| cfgStopSel | input | 2 | Stop length: 0 one bit, 1 one and a half, 2 or 3 two bits |
| rxLine | input | 1 | Serial input, idle high |
| txLine | output | 1 | Serial output, idle high |

## Verification
The hardest states to reach are the false start and the overrun, because both depend on timing at the serial input and not on any bus access. The bench drives the input with a low glitch a few ticks long, which is shorter than the half-bit confirmation point, and then sends a valid frame. For the overrun it sends two frames back to back with no read between them. A transmit and a receive frame are also launched together in a fork. Meanwhile a queue-based model of the output line is compared on every clock, which also catches any write that slips through while the transmitter is busy.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int OFS_DATA   = 'h10;
  localparam int OFS_RXSTAT = 'h14;
  localparam int OFS_TXSTAT = 'h18;

  typedef enum logic [2:0] {
    PH_IDLE, PH_START, PH_DATA, PH_PAR, PH_STOP
  } phase_e;

  typedef enum logic [1:0] {
    RD_NONE, RD_DATA, RD_RXSTAT, RD_TXSTAT
  } rdSel_e;

  typedef struct packed {
    logic   txLoad;
    logic   txShift;
    phase_e txKind;
    logic   txIdle;
    logic   rxSample;
    logic   rxParSample;
    logic   rxDone;
    logic   rdData;
    rdSel_e rdSel;
  } sioStrobes_t;
endpackage

// File: rtl/sio_ctrl.sv
module sio_ctrl import sio_pkg::*; #(
  parameter int TICK_DIV   = 4,
  parameter int OVERSAMPLE = 16,
  parameter int DATA_BITS  = 8,
  parameter int ADDR_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              cfgParityEn,
  input  logic [1:0]        cfgStopSel,
  input  logic              rxS,
  output sioStrobes_t       strb
);
  localparam int DIV_W  = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int HALF   = OVERSAMPLE / 2;
  localparam int TCNT_W = $clog2(2 * OVERSAMPLE);
  localparam int RCNT_W = $clog2(OVERSAMPLE);
  localparam int IDX_W  = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;

  localparam logic [DIV_W-1:0]  DIV_LAST  = DIV_W'(TICK_DIV - 1);
  localparam logic [TCNT_W-1:0] LEN_ONE   = TCNT_W'(OVERSAMPLE - 1);
  localparam logic [TCNT_W-1:0] LEN_HALF3 = TCNT_W'(OVERSAMPLE + HALF - 1);
  localparam logic [TCNT_W-1:0] LEN_TWO   = TCNT_W'(2 * OVERSAMPLE - 1);
  localparam logic [RCNT_W-1:0] R_LAST    = RCNT_W'(OVERSAMPLE - 1);
  localparam logic [RCNT_W-1:0] R_HALF    = RCNT_W'(HALF - 1);
  localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(DATA_BITS - 1);

  // shared oversample tick
  logic [DIV_W-1:0] divCnt;
  logic tick;
  assign tick = (divCnt == DIV_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     divCnt <= '0;
    else if (tick) divCnt <= '0;
    else           divCnt <= divCnt + 1'b1;
  end

  // bus decode
  logic hitData, hitRx, hitTx, wrData;
  assign hitData = busSel && (busAddr == ADDR_W'(OFS_DATA));
  assign hitRx   = busSel && (busAddr == ADDR_W'(OFS_RXSTAT));
  assign hitTx   = busSel && (busAddr == ADDR_W'(OFS_TXSTAT));
  assign wrData  = hitData && busWr;

  // transmit sequencer
  phase_e            txPh;
  logic [TCNT_W-1:0] txTicks, txLast;
  logic [IDX_W-1:0]  txIdx;
  logic              txParEnQ;
  logic [1:0]        txStopQ;
  logic              txLoad, txEnd;

  always_comb begin
    txLast = LEN_ONE;
    if (txPh == PH_STOP) begin
      case (txStopQ)
        2'd0:    txLast = LEN_ONE;
        2'd1:    txLast = LEN_HALF3;
        default: txLast = LEN_TWO;
      endcase
    end
  end

  assign txLoad = wrData && (txPh == PH_IDLE);
  assign txEnd  = tick && (txPh != PH_IDLE) && (txTicks == txLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txPh     <= PH_IDLE;
      txTicks  <= '0;
      txIdx    <= '0;
      txParEnQ <= 1'b0;
      txStopQ  <= 2'd0;
    end else if (txLoad) begin
      txPh     <= PH_START;
      txTicks  <= '0;
      txIdx    <= '0;
      txParEnQ <= cfgParityEn;
      txStopQ  <= cfgStopSel;
    end else if (txEnd) begin
      txTicks <= '0;
      case (txPh)
        PH_START: txPh <= PH_DATA;
        PH_DATA: begin
          if (txIdx == LAST_IDX) txPh <= txParEnQ ? PH_PAR : PH_STOP;
          else                   txIdx <= txIdx + 1'b1;
        end
        PH_PAR:  txPh <= PH_STOP;
        default: begin
          txPh  <= PH_IDLE;
          txIdx <= '0;
        end
      endcase
    end else if (tick && (txPh != PH_IDLE)) begin
      txTicks <= txTicks + 1'b1;
    end
  end

  // receive sequencer
  phase_e            rxPh;
  logic [RCNT_W-1:0] rxTicks;
  logic [IDX_W-1:0]  rxIdx;
  logic              rxMid;
  assign rxMid = tick && (rxTicks == R_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxPh    <= PH_IDLE;
      rxTicks <= '0;
      rxIdx   <= '0;
    end else if (tick) begin
      case (rxPh)
        PH_IDLE: begin
          rxTicks <= '0;
          if (!rxS) rxPh <= PH_START;
        end
        PH_START: begin
          if (rxTicks == R_HALF) begin
            rxTicks <= '0;
            rxIdx   <= '0;
            rxPh    <= rxS ? PH_IDLE : PH_DATA;
          end else begin
            rxTicks <= rxTicks + 1'b1;
          end
        end
        PH_DATA: begin
          if (rxTicks == R_LAST) begin
            rxTicks <= '0;
            if (rxIdx == LAST_IDX) rxPh <= cfgParityEn ? PH_PAR : PH_STOP;
            else                   rxIdx <= rxIdx + 1'b1;
          end else begin
            rxTicks <= rxTicks + 1'b1;
          end
        end
        PH_PAR: begin
          if (rxTicks == R_LAST) begin
            rxTicks <= '0;
            rxPh    <= PH_STOP;
          end else begin
            rxTicks <= rxTicks + 1'b1;
          end
        end
        default: begin
          if (rxTicks == R_LAST) begin
            rxTicks <= '0;
            rxPh    <= PH_IDLE;
          end else begin
            rxTicks <= rxTicks + 1'b1;
          end
        end
      endcase
    end
  end

  // strobes to the datapath
  always_comb begin
    strb.txLoad      = txLoad;
    strb.txShift     = txEnd && (txPh == PH_DATA);
    strb.txKind      = txPh;
    strb.txIdle      = (txPh == PH_IDLE);
    strb.rxSample    = rxMid && (rxPh == PH_DATA);
    strb.rxParSample = rxMid && (rxPh == PH_PAR);
    strb.rxDone      = rxMid && (rxPh == PH_STOP);
    strb.rdData      = hitData && !busWr;
    if (busWr)        strb.rdSel = RD_NONE;
    else if (hitData) strb.rdSel = RD_DATA;
    else if (hitRx)   strb.rdSel = RD_RXSTAT;
    else if (hitTx)   strb.rdSel = RD_TXSTAT;
    else              strb.rdSel = RD_NONE;
  end

  AST_TX_CFG_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (txPh != PH_IDLE) |=> ($stable(txStopQ) && $stable(txParEnQ))); // R4

  AST_RX_START_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rxPh) == PH_IDLE && rxPh == PH_START) |-> $past(!rxS)); // R8
endmodule

// File: rtl/sio_dp.sv
module sio_dp import sio_pkg::*; #(
  parameter int DATA_BITS = 8,
  parameter int BUS_W     = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  sioStrobes_t      strb,
  input  logic [BUS_W-1:0] busWdata,
  input  logic             cfgParityEn,
  input  logic             cfgParityOdd,
  input  logic             rxLine,
  output logic             rxS,
  output logic             txLine,
  output logic [BUS_W-1:0] busRdata
);
  logic [DATA_BITS-1:0] txSh;
  logic                 txParBit;
  logic                 unusedWdataHi;
  assign unusedWdataHi = ^busWdata[BUS_W-1:DATA_BITS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh     <= '0;
      txParBit <= 1'b0;
    end else if (strb.txLoad) begin
      txSh     <= busWdata[DATA_BITS-1:0];
      txParBit <= (^busWdata[DATA_BITS-1:0]) ^ cfgParityOdd;
    end else if (strb.txShift) begin
      txSh <= {1'b0, txSh[DATA_BITS-1:1]};
    end
  end

  always_comb begin
    case (strb.txKind)
      PH_START: txLine = 1'b0;
      PH_DATA:  txLine = txSh[0];
      PH_PAR:   txLine = txParBit;
      default:  txLine = 1'b1;
    endcase
  end

  // two-flop resynchroniser
  logic rxMeta;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxMeta <= 1'b1;
      rxS    <= 1'b1;
    end else begin
      rxMeta <= rxLine;
      rxS    <= rxMeta;
    end
  end

  logic [DATA_BITS-1:0] rxSh, rxData;
  logic rxParRcv, rxReady, rxOvr, rxPerr, parBad;
  assign parBad = cfgParityEn && (((^rxSh) ^ rxParRcv) != cfgParityOdd);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSh     <= '0;
      rxParRcv <= 1'b0;
    end else if (strb.rxSample) begin
      rxSh <= {rxS, rxSh[DATA_BITS-1:1]};
    end else if (strb.rxParSample) begin
      rxParRcv <= rxS;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData  <= '0;
      rxReady <= 1'b0;
      rxOvr   <= 1'b0;
      rxPerr  <= 1'b0;
    end else if (strb.rxDone) begin
      rxData  <= rxSh;
      rxReady <= 1'b1;
      rxOvr   <= rxReady && !strb.rdData;
      rxPerr  <= parBad;
    end else if (strb.rdData) begin
      rxReady <= 1'b0;
      rxOvr   <= 1'b0;
    end
  end

  always_comb begin
    case (strb.rdSel)
      RD_DATA:   busRdata = BUS_W'(rxData);
      RD_RXSTAT: busRdata = BUS_W'({rxPerr, rxOvr, rxReady});
      RD_TXSTAT: busRdata = BUS_W'(strb.txIdle);
      default:   busRdata = '0;
    endcase
  end

  AST_TX_START_LOW: assert property (@(posedge clk) disable iff (!rstN)
    strb.txLoad |=> !txLine); // R2

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    strb.txIdle |-> txLine); // R4

  AST_READ_CLEARS_READY: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdData && !strb.rxDone) |=> (!rxReady && !rxOvr)); // R7

  AST_OVERRUN_NEEDS_READY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxOvr) |-> $past(rxReady)); // R10
endmodule

// File: rtl/sio_port.sv
module sio_port import sio_pkg::*; #(
  parameter int TICK_DIV   = 4,
  parameter int OVERSAMPLE = 16,
  parameter int DATA_BITS  = 8,
  parameter int ADDR_W     = 8,
  parameter int BUS_W      = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  input  logic              cfgParityEn,
  input  logic              cfgParityOdd,
  input  logic [1:0]        cfgStopSel,
  input  logic              rxLine,
  output logic              txLine
);
  sioStrobes_t strb;
  logic        rxS;

  sio_ctrl #(
    .TICK_DIV(TICK_DIV), .OVERSAMPLE(OVERSAMPLE),
    .DATA_BITS(DATA_BITS), .ADDR_W(ADDR_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .cfgParityEn(cfgParityEn),
    .cfgStopSel(cfgStopSel), .rxS(rxS), .strb(strb)
  );

  sio_dp #(.DATA_BITS(DATA_BITS), .BUS_W(BUS_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .busWdata(busWdata),
    .cfgParityEn(cfgParityEn), .cfgParityOdd(cfgParityOdd),
    .rxLine(rxLine), .rxS(rxS), .txLine(txLine), .busRdata(busRdata)
  );
endmodule

// File: tb/sio_port_tb.sv
module sio_port_tb_top;
  localparam int TDIV = 4;
  localparam int BITC = 16 * TDIV;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWr = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        cfgParityEn = 1'b0, cfgParityOdd = 1'b0;
  logic [1:0]  cfgStopSel = 2'd0;
  logic        rxLine = 1'b1;
  logic        txLine;

  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  sio_port #(.TICK_DIV(TDIV)) dut_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .cfgParityEn(cfgParityEn), .cfgParityOdd(cfgParityOdd),
    .cfgStopSel(cfgStopSel), .rxLine(rxLine), .txLine(txLine)
  );

  // behavioural model of the serial output: queue of (level, ticks)
  int qLvl[$];
  int qLen[$];
  int mDiv = 0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qLvl.delete(); qLen.delete(); mDiv = 0;
    end else begin
      bit tk, wasIdle;
      tk = (mDiv == TDIV - 1);
      mDiv = (mDiv + 1) % TDIV;
      wasIdle = (qLen.size() == 0);
      if (tk && !wasIdle) begin
        qLen[0] = qLen[0] - 1;
        if (qLen[0] == 0) begin
          void'(qLvl.pop_front()); void'(qLen.pop_front());
        end
      end
      if (wasIdle && busSel && busWr && busAddr == 8'h10) begin
        qLvl.push_back(0); qLen.push_back(16);
        for (int i = 0; i < 8; i++) begin
          qLvl.push_back(int'(busWdata[i])); qLen.push_back(16);
        end
        if (cfgParityEn) begin
          qLvl.push_back(int'((^busWdata[7:0]) ^ cfgParityOdd)); qLen.push_back(16);
        end
        qLvl.push_back(1);
        qLen.push_back(cfgStopSel == 2'd0 ? 16 : (cfgStopSel == 2'd1 ? 24 : 32));
      end
    end
  end

  always @(negedge clk) begin
    if (rstN && !finished) begin
      logic expTx;
      expTx = (qLvl.size() > 0) ? qLvl[0][0] : 1'b1;
      total++;
      if (txLine !== expTx) begin
        bad++;
        $display("FAIL R2 R3 R4 R5 txLine act=%b exp=%b at %0t", txLine, expTx, $time);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0; busWdata = '0;
  endtask

  task automatic rdReg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic sendFrame(input logic [7:0] b, input bit parOn, input bit odd, input bit corrupt);
    @(negedge clk);
    rxLine = 1'b0;
    repeat (BITC) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxLine = b[i];
      repeat (BITC) @(negedge clk);
    end
    if (parOn) begin
      rxLine = (^b) ^ odd ^ corrupt;
      repeat (BITC) @(negedge clk);
    end
    rxLine = 1'b1;
    repeat (BITC) @(negedge clk);
  endtask

  task automatic waitTxIdle();
    while (qLen.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    chk("R1 txLine", {31'b0, txLine}, 32'h1);
    rdReg(8'h18, d); chk("R1 tx status", d, 32'h1);
    rdReg(8'h14, d); chk("R1 rx status", d, 32'h0);
    rdReg(8'h10, d); chk("R1 data", d, 32'h0);
    rdReg(8'h04, d); chk("R1 unmapped", d, 32'h0);

    // R2 R5: plain frame, busy status, ignored write
    wrReg(8'h10, 32'hFFFF_FFA5);
    rdReg(8'h18, d); chk("R5 tx busy", d, 32'h0);
    wrReg(8'h10, 32'h0000_003C);
    rdReg(8'h18, d); chk("R5 tx still busy", d, 32'h0);
    waitTxIdle();
    rdReg(8'h18, d); chk("R4 tx ready again", d, 32'h1);

    // R3 R4: even parity, 1.5 stop; odd parity, 2 stop
    cfgParityEn = 1'b1; cfgParityOdd = 1'b0; cfgStopSel = 2'd1;
    wrReg(8'h10, 32'h37);
    cfgParityOdd = 1'b1; cfgStopSel = 2'd0;
    waitTxIdle();
    cfgStopSel = 2'd2;
    wrReg(8'h10, 32'h80);
    waitTxIdle();
    cfgStopSel = 2'd3;
    wrReg(8'h10, 32'h5B);
    waitTxIdle();
    rdReg(8'h18, d); chk("R4 tx ready after two stops", d, 32'h1);

    // R6 R7: receive without parity
    cfgParityEn = 1'b0; cfgStopSel = 2'd0;
    sendFrame(8'h5A, 1'b0, 1'b0, 1'b0);
    rdReg(8'h14, d); chk("R6 rx ready", d, 32'h1);
    rdReg(8'h10, d); chk("R6 rx byte", d, 32'h5A);
    rdReg(8'h14, d); chk("R7 ready cleared", d, 32'h0);

    // R8 false start
    @(negedge clk); rxLine = 1'b0;
    repeat (3 * TDIV) @(negedge clk);
    rxLine = 1'b1;
    repeat (2 * BITC) @(negedge clk);
    rdReg(8'h14, d); chk("R8 glitch ignored", d, 32'h0);
    sendFrame(8'hC3, 1'b0, 1'b0, 1'b0);
    rdReg(8'h10, d); chk("R8 frame after glitch", d, 32'hC3);

    // R10 overrun
    sendFrame(8'h11, 1'b0, 1'b0, 1'b0);
    sendFrame(8'h22, 1'b0, 1'b0, 1'b0);
    rdReg(8'h14, d); chk("R10 overrun status", d, 32'h3);
    rdReg(8'h10, d); chk("R10 newest byte kept", d, 32'h22);
    rdReg(8'h14, d); chk("R7 overrun cleared", d, 32'h0);

    // R9 parity checking
    cfgParityEn = 1'b1; cfgParityOdd = 1'b0;
    sendFrame(8'h0F, 1'b1, 1'b0, 1'b0);
    rdReg(8'h14, d); chk("R9 good even parity", d, 32'h1);
    rdReg(8'h10, d); chk("R9 byte", d, 32'h0F);
    sendFrame(8'h0F, 1'b1, 1'b0, 1'b1);
    rdReg(8'h14, d); chk("R9 bad parity flagged", d, 32'h5);
    rdReg(8'h10, d); chk("R9 byte with bad parity", d, 32'h0F);
    rdReg(8'h14, d); chk("R9 flag held after read", d, 32'h4);
    cfgParityOdd = 1'b1;
    sendFrame(8'h01, 1'b1, 1'b1, 1'b0);
    rdReg(8'h14, d); chk("R9 flag cleared by good odd frame", d, 32'h1);
    rdReg(8'h10, d); chk("R9 odd byte", d, 32'h01);

    // R11 full duplex
    cfgStopSel = 2'd1;
    fork
      wrReg(8'h10, 32'h69);
      sendFrame(8'h4B, 1'b1, 1'b1, 1'b0);
    join
    rdReg(8'h10, d); chk("R11 rx during tx", d, 32'h4B);
    waitTxIdle();
    rdReg(8'h18, d); chk("R11 tx done", d, 32'h1);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule